// File: doc/BRIEF.md
# Burst Abort Controller

This block ends a receive burst on request and resets the bookkeeping kept for that burst. A request comes from either of two sources: a level input from a pin, and a single bit held in a control register that software sets through a write strobe. The two levels are OR-combined. A request is the rising edge of that combination. In effect, a source that stays low leaves the other source free to raise a request, and a source that stays high masks the other one.

All logic runs on one system clock. The baseband sampling clock arrives as a one-cycle enable. After a request, the controller waits for two sampling enables and then executes the abort. Executing the abort clears the sample-in-symbol counter, the symbol counter and the missed-detect counter. It also puts the counters to sleep and raises a one-cycle completion pulse.

The counters stay asleep until an acquisition detect or a manual detect wakes them. While awake, the sample counter steps on each sampling enable and wraps after a programmable last value. Each wrap advances the symbol counter. The missed-detect counter steps on each missed-detect strobe and saturates.

Top module: `burst_abort_ctl`

States of the abort sequencer:
- IDLE: no abort pending.
- WAIT1: a request was seen, and no sampling enable has arrived since.
- WAIT2: one sampling enable has arrived since the request.

Transitions:
- Request: any state goes to WAIT1.
- First enable: WAIT1 goes to WAIT2.
- Execute: WAIT2 goes to IDLE on a sampling enable with no request in the same cycle.

## Requirements
- R1: After reset, all three counters read zero, `cnt_live` is 0, `abort_done` is 0 and the register bit is 0.
- R2: A request is a 0-to-1 transition of (`abort_pin` OR register bit). The register bit is loaded from `cfg_d0` in the cycle `cfg_wr` is 1. While either source is high, transitions of the other source raise no request.
- R3: An abort executes at the second clock edge with `smp_en`=1 that strictly follows the edge at which the request is taken. `smp_en` in the request cycle itself does not count. `abort_done` is 1 for exactly the one cycle after that execution edge.
- R4: In the cycle `abort_done` is 1, `smp_cnt`, `sym_cnt` and `miss_cnt` are all zero and `cnt_live` is 0.
- R5: A request that arrives while an abort is pending, including in the cycle that would execute it, restarts the two-enable wait without executing. Only one abort results.
- R6: While `cnt_live` is 0, the counters do not change. A cycle with `acq_det` or `man_det` at 1 sets `cnt_live` to 1 at the next edge. Both detects have no effect while `cnt_live` is already 1.
- R7: While `cnt_live` is 1, each `smp_en` increments `smp_cnt`. When `smp_cnt` is at or above `sps_last`, that `smp_en` loads 0 instead and increments `sym_cnt` (modulo 2^SYM_W).
- R8: While `cnt_live` is 1, each `miss_stb` increments `miss_cnt`, which holds at all ones once reached.
- R9: Clearing has priority. A detect in the same cycle as an executing abort leaves `cnt_live` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_pin | input | 1 | Abort source level from the pin |
| cfg_wr | input | 1 | Write strobe for the abort register bit |
| cfg_d0 | input | 1 | Data bit 0 written to the abort register bit |
| smp_en | input | 1 | One-cycle baseband sampling enable |
| acq_det | input | 1 | Acquisition/preamble symbol detect strobe |
| man_det | input | 1 | Manual detect strobe |
| miss_stb | input | 1 | Expected-but-absent detect strobe |
| sps_last | input | SMP_W | Last value of the sample counter before wrap |
| smp_cnt | output | SMP_W | Samples counted in the current symbol |
| sym_cnt | output | SYM_W | Symbols counted in the burst |
| miss_cnt | output | MISS_W | Missed detects in the burst, saturating |
| cnt_live | output | 1 | Counters awake |
| abort_done | output | 1 | One-cycle pulse after an abort has cleared the counters |

## Verification
The bench builds the block with SMP_W=4, SYM_W=6 and MISS_W=3. The narrow missed-detect counter reaches its saturation value of 7 within nine strobes. The sample-counter wrap is run with sps_last values of 3 and 0. The 0 case advances the symbol counter on every enable. With these widths, the restart of a pending abort and the race between a detect and an executing abort both fit within a few dozen cycles.

// File: rtl/bac_pkg.sv
package bac_pkg;
    typedef enum logic [1:0] {
        ABT_IDLE  = 2'd0,
        ABT_WAIT1 = 2'd1,
        ABT_WAIT2 = 2'd2
    } abt_state_e;
endpackage

// File: rtl/bac_trig.sv
module bac_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_pin,
    input  logic cfg_wr,
    input  logic cfg_d0,
    output logic trig
);
    logic reg_bit_q;
    logic comb_q;
    logic comb_w;

    // Either source held high masks the other one.
    assign comb_w = abort_pin | reg_bit_q;
    assign trig   = comb_w & ~comb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_bit_q <= 1'b0;
            comb_q    <= 1'b0;
        end else begin
            comb_q <= comb_w;
            if (cfg_wr) begin
                reg_bit_q <= cfg_d0;
            end
        end
    end
endmodule

// File: rtl/bac_fsm.sv
module bac_fsm
    import bac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic smp_en,
    output logic exec,
    output logic done
);
    abt_state_e state_q;
    abt_state_e state_d;
    logic       done_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ABT_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= exec;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        exec    = 1'b0;
        unique case (state_q)
            ABT_IDLE: begin
                if (trig) state_d = ABT_WAIT1;
            end
            ABT_WAIT1: begin
                if (trig)        state_d = ABT_WAIT1;
                else if (smp_en) state_d = ABT_WAIT2;
            end
            ABT_WAIT2: begin
                if (trig) begin
                    state_d = ABT_WAIT1;
                end else if (smp_en) begin
                    state_d = ABT_IDLE;
                    exec    = 1'b1;
                end
            end
            default: state_d = ABT_IDLE;
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/bac_cnt.sv
module bac_cnt #(
    parameter int SMP_W  = 8,
    parameter int SYM_W  = 12,
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              smp_en,
    input  logic              acq_det,
    input  logic              man_det,
    input  logic              miss_stb,
    input  logic [SMP_W-1:0]  sps_last,
    output logic [SMP_W-1:0]  smp_cnt,
    output logic [SYM_W-1:0]  sym_cnt,
    output logic [MISS_W-1:0] miss_cnt,
    output logic              live
);
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    logic [SMP_W-1:0]  smp_q;
    logic [SYM_W-1:0]  sym_q;
    logic [MISS_W-1:0] miss_q;
    logic              live_q;
    logic              wrap_w;

    assign wrap_w = (smp_q >= sps_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= '0;
            sym_q  <= '0;
            miss_q <= '0;
            live_q <= 1'b0;
        end else if (clr) begin
            smp_q  <= '0;
            sym_q  <= '0;
            miss_q <= '0;
            live_q <= 1'b0;
        end else if (live_q) begin
            if (smp_en) begin
                if (wrap_w) begin
                    smp_q <= '0;
                    sym_q <= sym_q + 1'b1;
                end else begin
                    smp_q <= smp_q + 1'b1;
                end
            end
            if (miss_stb && (miss_q != MISS_MAX)) begin
                miss_q <= miss_q + 1'b1;
            end
        end else if (acq_det || man_det) begin
            live_q <= 1'b1;
        end
    end

    assign smp_cnt  = smp_q;
    assign sym_cnt  = sym_q;
    assign miss_cnt = miss_q;
    assign live     = live_q;
endmodule

// File: rtl/burst_abort_ctl.sv
module burst_abort_ctl #(
    parameter int SMP_W  = 8,
    parameter int SYM_W  = 12,
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_pin,
    input  logic              cfg_wr,
    input  logic              cfg_d0,
    input  logic              smp_en,
    input  logic              acq_det,
    input  logic              man_det,
    input  logic              miss_stb,
    input  logic [SMP_W-1:0]  sps_last,
    output logic [SMP_W-1:0]  smp_cnt,
    output logic [SYM_W-1:0]  sym_cnt,
    output logic [MISS_W-1:0] miss_cnt,
    output logic              cnt_live,
    output logic              abort_done
);
    logic trig_w;
    logic exec_w;

    bac_trig trig_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_pin (abort_pin),
        .cfg_wr    (cfg_wr),
        .cfg_d0    (cfg_d0),
        .trig      (trig_w)
    );

    bac_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig_w),
        .smp_en (smp_en),
        .exec   (exec_w),
        .done   (abort_done)
    );

    bac_cnt #(
        .SMP_W  (SMP_W),
        .SYM_W  (SYM_W),
        .MISS_W (MISS_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (exec_w),
        .smp_en   (smp_en),
        .acq_det  (acq_det),
        .man_det  (man_det),
        .miss_stb (miss_stb),
        .sps_last (sps_last),
        .smp_cnt  (smp_cnt),
        .sym_cnt  (sym_cnt),
        .miss_cnt (miss_cnt),
        .live     (cnt_live)
    );
endmodule

// File: rtl/bac_chk.sv
module bac_chk #(
    parameter int SMP_W  = 8,
    parameter int SYM_W  = 12,
    parameter int MISS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_en,
    input logic              exec,
    input logic              acq_det,
    input logic              man_det,
    input logic              abort_done,
    input logic              cnt_live,
    input logic [SMP_W-1:0]  sps_last,
    input logic [SMP_W-1:0]  smp_cnt,
    input logic [SYM_W-1:0]  sym_cnt,
    input logic [MISS_W-1:0] miss_cnt
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |=> !abort_done);

    a_r3_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |-> $past(smp_en));

    a_r4_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |-> (smp_cnt == '0 && sym_cnt == '0 && miss_cnt == '0 && !cnt_live));

    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_live |=> ($stable(smp_cnt) && $stable(sym_cnt) && $stable(miss_cnt)));

    a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_live && (acq_det || man_det) && !exec) |=> cnt_live);

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_live && smp_en && !exec && smp_cnt == sps_last)
        |=> (smp_cnt == '0 && sym_cnt == SYM_W'($past(sym_cnt) + 1'b1)));

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_live && !exec && miss_cnt == {MISS_W{1'b1}}) |=> (miss_cnt == {MISS_W{1'b1}}));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !cnt_live);
endmodule

bind burst_abort_ctl bac_chk #(
    .SMP_W  (SMP_W),
    .SYM_W  (SYM_W),
    .MISS_W (MISS_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .exec       (exec_w),
    .acq_det    (acq_det),
    .man_det    (man_det),
    .abort_done (abort_done),
    .cnt_live   (cnt_live),
    .sps_last   (sps_last),
    .smp_cnt    (smp_cnt),
    .sym_cnt    (sym_cnt),
    .miss_cnt   (miss_cnt)
);

// File: tb/burst_abort_ctl_tb_top.sv
module burst_abort_ctl_tb_top;
    localparam int SMP_W  = 4;
    localparam int SYM_W  = 6;
    localparam int MISS_W = 3;

    typedef struct {
        string             tag;
        logic [SMP_W-1:0]  smp;
        logic [SYM_W-1:0]  sym;
        logic [MISS_W-1:0] miss;
        logic              live;
        logic              done;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              abort_pin = 1'b0;
    logic              cfg_wr = 1'b0;
    logic              cfg_d0 = 1'b0;
    logic              smp_en = 1'b0;
    logic              acq_det = 1'b0;
    logic              man_det = 1'b0;
    logic              miss_stb = 1'b0;
    logic [SMP_W-1:0]  sps_last = 4'd3;
    logic [SMP_W-1:0]  smp_cnt;
    logic [SYM_W-1:0]  sym_cnt;
    logic [MISS_W-1:0] miss_cnt;
    logic              cnt_live;
    logic              abort_done;

    int    total = 0;
    int    bad = 0;
    int    done_seen = 0;
    int    m_done_total = 0;
    string tag = "R1";
    exp_t  sb_q[$];

    // Reference state kept from the requirements
    logic              m_prev = 1'b0;
    logic              m_reg = 1'b0;
    int                m_pend = 0;
    logic              m_live = 1'b0;
    logic [SMP_W-1:0]  m_smp = '0;
    logic [SYM_W-1:0]  m_sym = '0;
    logic [MISS_W-1:0] m_miss = '0;

    always #10 clk = ~clk;

    burst_abort_ctl #(
        .SMP_W  (SMP_W),
        .SYM_W  (SYM_W),
        .MISS_W (MISS_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_pin  (abort_pin),
        .cfg_wr     (cfg_wr),
        .cfg_d0     (cfg_d0),
        .smp_en     (smp_en),
        .acq_det    (acq_det),
        .man_det    (man_det),
        .miss_stb   (miss_stb),
        .sps_last   (sps_last),
        .smp_cnt    (smp_cnt),
        .sym_cnt    (sym_cnt),
        .miss_cnt   (miss_cnt),
        .cnt_live   (cnt_live),
        .abort_done (abort_done)
    );

    task automatic chk(input string t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic pin_v, input logic wr_v, input logic d0_v,
                        input logic se_v, input logic acq_v, input logic man_v,
                        input logic ms_v);
        logic comb, trg, ex;
        exp_t e;
        abort_pin = pin_v; cfg_wr = wr_v; cfg_d0 = d0_v; smp_en = se_v;
        acq_det = acq_v; man_det = man_v; miss_stb = ms_v;
        comb = pin_v | m_reg;
        trg  = comb & ~m_prev;
        ex   = !trg && (m_pend == 2) && se_v;
        if (trg)                     m_pend = 1;
        else if (se_v && m_pend == 1) m_pend = 2;
        else if (ex)                 m_pend = 0;
        if (ex) begin
            m_smp = '0; m_sym = '0; m_miss = '0; m_live = 1'b0;
            m_done_total++;
        end else if (m_live) begin
            if (se_v) begin
                if (m_smp >= sps_last) begin m_smp = '0; m_sym = m_sym + 1'b1; end
                else m_smp = m_smp + 1'b1;
            end
            if (ms_v && m_miss != {MISS_W{1'b1}}) m_miss = m_miss + 1'b1;
        end else if (acq_v || man_v) begin
            m_live = 1'b1;
        end
        m_prev = comb;
        if (wr_v) m_reg = d0_v;
        @(posedge clk);
        #1;
        e.tag = tag; e.smp = m_smp; e.sym = m_sym; e.miss = m_miss;
        e.live = m_live; e.done = ex;
        sb_q.push_back(e);
        cfg_wr = 1'b0; smp_en = 1'b0; acq_det = 1'b0; man_det = 1'b0; miss_stb = 1'b0;
    endtask

    // Monitor: compares design results with the queued expectations
    always @(negedge clk) begin
        if (rst_n && abort_done) done_seen++;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " smp_cnt"},    int'(smp_cnt),    int'(e.smp));
            chk({e.tag, " sym_cnt"},    int'(sym_cnt),    int'(e.sym));
            chk({e.tag, " miss_cnt"},   int'(miss_cnt),   int'(e.miss));
            chk({e.tag, " cnt_live"},   int'(cnt_live),   int'(e.live));
            chk({e.tag, " abort_done"}, int'(abort_done), int'(e.done));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 smp_cnt", int'(smp_cnt), 0);
        chk("R1 cnt_live", int'(cnt_live), 0);
        chk("R1 abort_done", int'(abort_done), 0);
        rst_n = 1'b1;
        tag = "R1";
        repeat (2) step(0, 0, 0, 0, 0, 0, 0);
        // R6: idle counters ignore enables and strobes
        tag = "R6";
        repeat (3) step(0, 0, 0, 1, 0, 0, 1);
        step(0, 0, 0, 0, 1, 0, 0);
        // R7: sample wrap at sps_last=3
        tag = "R7";
        repeat (10) step(0, 0, 0, 1, 0, 0, 0);
        @(negedge clk); #1;
        chk("R7 sym after 10", int'(sym_cnt), 2);
        chk("R7 smp after 10", int'(smp_cnt), 2);
        // R8: saturation
        tag = "R8";
        repeat (9) step(0, 0, 0, 0, 0, 0, 1);
        @(negedge clk); #1;
        chk("R8 saturated", int'(miss_cnt), 7);
        tag = "R6";
        step(0, 0, 0, 0, 1, 1, 0);
        // R3: pin request, two enables later
        tag = "R3";
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R3 one abort", done_seen, 1);
        // R6: frozen, then manual detect wakes
        tag = "R6";
        repeat (3) step(1, 0, 0, 1, 0, 0, 1);
        step(1, 0, 0, 0, 0, 1, 0);
        repeat (5) step(1, 0, 0, 1, 0, 0, 0);
        // R2: masking while one source stays high
        tag = "R2";
        step(1, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R2 masked no abort", done_seen, 1);
        // R2: register bit request while pin low
        step(0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R2 register request", done_seen, 2);
        // R5: restart of a pending abort
        tag = "R5";
        step(0, 1, 0, 0, 0, 1, 0);
        repeat (2) step(0, 0, 0, 1, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R5 still pending", done_seen, 2);
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R5 single abort", done_seen, 3);
        // R9: detect in the executing cycle
        tag = "R9";
        step(0, 0, 0, 0, 0, 1, 0);
        repeat (2) step(0, 0, 0, 1, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 1, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R9 live after race", int'(cnt_live), 0);
        // R7: sps_last = 0 advances symbols on every enable
        tag = "R7";
        sps_last = '0;
        step(1, 0, 0, 0, 0, 1, 0);
        repeat (3) step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R7 sym with last=0", int'(sym_cnt), 3);
        chk("R3 total aborts", done_seen, m_done_total);
        @(negedge clk);
        #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule